// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This peripheral keeps a 32-bit count of elapsed seconds and raises an alarm when that count reaches a programmed value. A prescaler divides the system clock down to a single-cycle enable once per second, and each enable advances the count by one. The count wraps modulo 2^32. Software reaches the block over a 32-bit APB-style register bus. Through it, software can preset the count, program the alarm value, enable the interrupt, and acknowledge a pending alarm. A fixed set of identification bytes can be read from the top of the 4 KB window.

The alarm is a sticky raw status bit. It is compared on every tick, and it is also compared at the moment software writes either the alarm value or the preset value. As a result, an alarm that is already equal fires at once and never waits for a full wrap. A one-bit enable gates the raw bit onto the level interrupt output. The control word is fixed at "running".

Top module: `rtc_alarm_top`

## Requirements
- R1: The count advances by exactly one on every prescaler tick. With divider D, the first tick after reset comes on the D-th rising edge and later ticks come every D cycles. Between ticks the count holds its value.
- R2: A write to byte offset 0x08 replaces the running count with the written data; if a tick lands on the same edge, the write takes priority. A read of 0x08 returns the last value written there.
- R3: The alarm test is plain equality, so an alarm value of 0 is reached when the count wraps from 0xFFFFFFFF to 0.
- R4: A write to the alarm value at 0x04 (readable there) or to the preset at 0x08 compares the new count with the new alarm value. If they are equal, the raw bit (0x14, bit 0) is set by that same access.
- R5: The interrupt-enable word at 0x10 keeps only bit 0 of the write data. Offset 0x18 reads raw AND enable, and the irq output carries the same value.
- R6: A write of any data, including 0, to 0x1C clears the raw bit.
- R7: Offset 0x0C always reads 1, and writes to it change nothing.
- R8: Reads of the eight words from 0xFE0 to 0xFFC return, in address order, 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, each in bits 7:0.
- R9: Writes to 0x00, 0x14 and 0x18 have no effect. Reads of 0x1C and of undefined offsets return 0.
- R10: After reset the count, alarm value, preset, enable and raw bit are all 0 and the prescaler restarts.
- R11: If a tick that makes the count equal to the alarm value lands on the same edge as a write to 0x1C, the raw bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while a read is selected |
| irq | output | 1 | Level interrupt: raw alarm AND enable |

## Verification
The alarm logic is exercised by several patterns, and each one isolates a different part of it:
- A count preset just below the wrap point shows whether equality survives the 0xFFFFFFFF-to-0 rollover.
- Alarm and preset writes that land on an already-equal value separate the immediate compare from the tick-driven compare.
- A preset write placed on a tick edge shows which of the two wins.
- A clear write placed on the tick that makes the alarm true shows whether set or clear has priority.
- Enable writes with stray upper bits show that only bit 0 is kept.
- Writes with zero data to the clear word show that the data value is ignored.

A behavioural model in the bench follows every edge. It is compared with irq on every cycle and with prdata on every read.

// File: rtl/rtc_alarm_pkg.sv
// Package: shared word indices, write-strobe bundle and identification bytes
// for the seconds-counter alarm peripheral. Assumes a 4 KB word-addressed window.
package rtc_alarm_pkg;

    // Word indices (byte offset / 4) of the programmer-visible words.
    localparam int unsigned IDX_COUNT   = 0;
    localparam int unsigned IDX_ALARM   = 1;
    localparam int unsigned IDX_PRESET  = 2;
    localparam int unsigned IDX_CTRL    = 3;
    localparam int unsigned IDX_ENABLE  = 4;
    localparam int unsigned IDX_RAW     = 5;
    localparam int unsigned IDX_GATED   = 6;
    localparam int unsigned IDX_ACK     = 7;
    // First word of the identification window (byte 0xFE0).
    localparam int unsigned IDX_ID_BASE = 'h3F8;
    localparam int unsigned ID_WORDS    = 8;

    // One-cycle write strobes decoded from a bus access.
    typedef struct packed {
        logic preset;
        logic alarm;
        logic enable;
        logic ack;
    } wr_strobe_t;

    // Identification byte for a slot of the ID window.
    function automatic logic [7:0] ident_byte(input logic [2:0] slot);
        logic [7:0] b;
        case (slot)
            3'd0:    b = 8'h31;
            3'd1:    b = 8'h10;
            3'd2:    b = 8'h14;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Module: rtc_prescaler
// Divides the system clock into a single-cycle enable pulse once every
// TICK_DIV cycles. Assumes TICK_DIV >= 2. Synchronous active-low reset
// restarts the division from zero.
module rtc_prescaler #(
    parameter int unsigned TICK_DIV = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] phase_q;

    // Pulse on the final phase of each division period.
    assign tick = (phase_q == LAST);

    // Advance the phase, folding back to zero after the final phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PW'(1);
        end
    end
endmodule

// File: rtl/rtc_seconds_core.sv
// Module: rtc_seconds_core
// Holds the seconds count, the alarm value, the last preset and the sticky
// raw alarm bit. The alarm is compared on every tick and on every write to
// the alarm value or the preset, using the values those events produce.
// A set on the same edge as an acknowledge wins. Assumes strobes last one cycle.
module rtc_seconds_core #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_preset,
    input  logic          wr_alarm,
    input  logic          wr_ack,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] count,
    output logic [DW-1:0] alarm_val,
    output logic [DW-1:0] preset_val,
    output logic          raw
);
    logic [DW-1:0] count_nxt;
    logic [DW-1:0] alarm_nxt;
    logic          compare_now;
    logic          hit;

    // Next count: a preset overrides the tick increment.
    always_comb begin
        if (wr_preset) begin
            count_nxt = wdata;
        end else begin
            count_nxt = count + DW'(tick);
        end
    end

    // Next alarm value: replaced only by an alarm write.
    assign alarm_nxt   = wr_alarm ? wdata : alarm_val;
    // Compare only on events that can change either side.
    assign compare_now = tick | wr_preset | wr_alarm;
    assign hit         = compare_now && (count_nxt == alarm_nxt);

    // Count and alarm storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count     <= '0;
            alarm_val <= '0;
        end else begin
            count     <= count_nxt;
            alarm_val <= alarm_nxt;
        end
    end

    // Remember the last preset written so it can be read back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preset_val <= '0;
        end else if (wr_preset) begin
            preset_val <= wdata;
        end
    end

    // Sticky raw alarm: set has priority over acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw <= 1'b0;
        end else if (hit) begin
            raw <= 1'b1;
        end else if (wr_ack) begin
            raw <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_bus_decode.sv
// Module: rtc_bus_decode
// Decodes APB-style accesses into one-cycle write strobes, holds the
// interrupt-enable bit and forms read data. Writes take effect on the access
// phase (psel & penable & pwrite). Read data is combinational and zero when
// no read is selected. Assumes AW >= 12 so the ID window fits.
module rtc_bus_decode
    import rtc_alarm_pkg::*;
#(
    parameter int unsigned AW = 12,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    input  logic [DW-1:0] count,
    input  logic [DW-1:0] alarm_val,
    input  logic [DW-1:0] preset_val,
    input  logic          raw,
    output wr_strobe_t    strb,
    output logic          enable,
    output logic [DW-1:0] prdata
);
    localparam int unsigned WIDX = AW - 2;
    localparam logic [WIDX-1:0] W_COUNT  = WIDX'(IDX_COUNT);
    localparam logic [WIDX-1:0] W_ALARM  = WIDX'(IDX_ALARM);
    localparam logic [WIDX-1:0] W_PRESET = WIDX'(IDX_PRESET);
    localparam logic [WIDX-1:0] W_CTRL   = WIDX'(IDX_CTRL);
    localparam logic [WIDX-1:0] W_ENABLE = WIDX'(IDX_ENABLE);
    localparam logic [WIDX-1:0] W_RAW    = WIDX'(IDX_RAW);
    localparam logic [WIDX-1:0] W_GATED  = WIDX'(IDX_GATED);
    localparam logic [WIDX-1:0] W_ID_LO  = WIDX'(IDX_ID_BASE);
    localparam logic [WIDX-1:0] W_ID_HI  = WIDX'(IDX_ID_BASE + ID_WORDS - 1);
    localparam logic [WIDX-1:0] W_ACK    = WIDX'(IDX_ACK);

    logic [WIDX-1:0] word;
    logic            wr_access;
    logic            rd_select;
    logic            in_id;

    assign word      = paddr[AW-1:2];
    assign wr_access = psel & penable & pwrite;
    assign rd_select = psel & ~pwrite;
    assign in_id     = (word >= W_ID_LO) && (word <= W_ID_HI);

    // One-cycle write strobes; writes to read-only words produce none.
    always_comb begin
        strb.preset = wr_access && (word == W_PRESET);
        strb.alarm  = wr_access && (word == W_ALARM);
        strb.enable = wr_access && (word == W_ENABLE);
        strb.ack    = wr_access && (word == W_ACK);
    end

    // Interrupt enable keeps bit 0 of the write data only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= 1'b0;
        end else if (strb.enable) begin
            enable <= pwdata[0];
        end
    end

    // Read data multiplexer; unknown and write-only words read as zero.
    always_comb begin
        prdata = '0;
        if (rd_select) begin
            if (in_id) begin
                prdata = DW'(ident_byte(word[2:0]));
            end else begin
                case (word)
                    W_COUNT:  prdata = count;
                    W_ALARM:  prdata = alarm_val;
                    W_PRESET: prdata = preset_val;
                    W_CTRL:   prdata = DW'(1);
                    W_ENABLE: prdata = DW'(enable);
                    W_RAW:    prdata = DW'(raw);
                    W_GATED:  prdata = DW'(raw & enable);
                    W_ACK:    prdata = '0;
                    default:  prdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/rtc_alarm_top.sv
// Module: rtc_alarm_top
// Seconds counter with match alarm on an APB-style bus. Ties together the
// prescaler, the counter/alarm core and the bus decode, and drives the level
// interrupt as raw alarm AND enable. Assumes a single clock domain.
module rtc_alarm_top
    import rtc_alarm_pkg::*;
#(
    parameter int unsigned TICK_DIV = 50_000_000,
    parameter int unsigned AW       = 12,
    parameter int unsigned DW       = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    output logic [DW-1:0] prdata,
    output logic          irq
);
    logic          tick;
    wr_strobe_t    strb;
    logic          wr_preset;
    logic          wr_alarm;
    logic          wr_ack;
    logic [DW-1:0] count;
    logic [DW-1:0] alarm_val;
    logic [DW-1:0] preset_val;
    logic          raw;
    logic          enable;

    assign wr_preset = strb.preset;
    assign wr_alarm  = strb.alarm;
    assign wr_ack    = strb.ack;

    rtc_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    rtc_seconds_core #(.DW(DW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .wr_preset  (wr_preset),
        .wr_alarm   (wr_alarm),
        .wr_ack     (wr_ack),
        .wdata      (pwdata),
        .count      (count),
        .alarm_val  (alarm_val),
        .preset_val (preset_val),
        .raw        (raw)
    );

    rtc_bus_decode #(.AW(AW), .DW(DW)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .pwdata     (pwdata),
        .count      (count),
        .alarm_val  (alarm_val),
        .preset_val (preset_val),
        .raw        (raw),
        .strb       (strb),
        .enable     (enable),
        .prdata     (prdata)
    );

    // Level interrupt: raw alarm gated by the enable bit.
    assign irq = raw & enable;
endmodule

// File: rtl/rtc_alarm_checker.sv
// Module: rtc_alarm_checker
// Temporal properties of the counter and the alarm bit, attached to the top
// module by the bind below. Observes only; drives nothing.
module rtc_alarm_checker #(
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          wr_preset,
    input logic          wr_alarm,
    input logic          wr_ack,
    input logic [DW-1:0] pwdata,
    input logic [DW-1:0] count,
    input logic          raw
);
    // R1: without a tick or preset the count holds.
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_preset) |=> $stable(count));

    // R1: a tick alone advances the count by one.
    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_preset) |=> (count == $past(count) + DW'(1)));

    // R2: a preset write lands in the count on the next cycle.
    assert_preset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_preset |=> (count == $past(pwdata)));

    // R4: an alarm write equal to a steady count sets the raw bit at once.
    assert_instant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_alarm && !wr_preset && !tick && (count == pwdata)) |=> raw);

    // R4: the raw bit rises only after a compare event.
    assert_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw) |-> $past(tick || wr_preset || wr_alarm));

    // R6: an acknowledge with no competing event clears the raw bit.
    assert_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && !tick && !wr_preset && !wr_alarm) |=> !raw);
endmodule

bind rtc_alarm_top rtc_alarm_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wr_preset (wr_preset),
    .wr_alarm  (wr_alarm),
    .wr_ack    (wr_ack),
    .pwdata    (pwdata),
    .count     (count),
    .raw       (raw)
);

// File: tb/rtc_alarm_top_test.sv
// Bench for rtc_alarm_top: behavioural model updated on every rising edge,
// compared with irq on every cycle and with prdata on every read.
module rtc_alarm_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    // Model state
    logic [31:0] m_cnt, m_mat, m_ld;
    logic        m_en, m_raw;
    int          m_pc;
    logic        m_tk, m_wr, m_cmp;
    logic [31:0] n_cnt, n_mat;

    rtc_alarm_top #(.TICK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: one step per rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_mat = 0; m_ld = 0; m_en = 0; m_raw = 0; m_pc = 0;
        end else begin
            m_tk = (m_pc == DIV - 1);
            m_pc = m_tk ? 0 : m_pc + 1;
            m_wr = psel && penable && pwrite;
            n_cnt = m_cnt + (m_tk ? 32'd1 : 32'd0);
            n_mat = m_mat;
            m_cmp = m_tk;
            if (m_wr && paddr == 12'h008) begin n_cnt = pwdata; m_ld = pwdata; m_cmp = 1; end
            if (m_wr && paddr == 12'h004) begin n_mat = pwdata; m_cmp = 1; end
            if (m_wr && paddr == 12'h010) m_en = pwdata[0];
            if (m_cmp && n_cnt == n_mat) m_raw = 1;
            else if (m_wr && paddr == 12'h01C) m_raw = 0;
            m_cnt = n_cnt; m_mat = n_mat;
        end
    end

    function automatic logic [31:0] model_read(input logic [11:0] a);
        logic [7:0] ids [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        if (a >= 12'hFE0) return {24'd0, ids[a[4:2]]};
        case (a)
            12'h000: return m_cnt;
            12'h004: return m_mat;
            12'h008: return m_ld;
            12'h00C: return 32'd1;
            12'h010: return {31'd0, m_en};
            12'h014: return {31'd0, m_raw};
            12'h018: return {31'd0, m_raw & m_en};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // R5: irq compared with the model on every cycle.
    always @(negedge clk) begin
        if (rst_n) check("R5 irq", {31'd0, irq}, {31'd0, m_raw & m_en});
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    // Write whose access edge coincides with a prescaler tick.
    task automatic bus_write_on_tick(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        while (m_pc != DIV - 2) @(negedge clk);
        psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_read(input logic [11:0] a, input string tag);
        @(negedge clk);
        psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk);
        penable = 1;
        #1 check(tag, prdata, model_read(a));
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic read_exp(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk);
        penable = 1;
        #1 check(tag, prdata, exp);
        check({tag, " model"}, prdata, model_read(a));
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic wait_after_tick();
        @(negedge clk);
        while (m_pc != 0) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R10: reset state
        read_exp(12'h000, 32'd0, "R10 count");
        read_exp(12'h004, 32'd0, "R10 alarm");
        read_exp(12'h008, 32'd0, "R10 preset");
        read_exp(12'h010, 32'd0, "R10 enable");
        read_exp(12'h014, 32'd0, "R10 raw");
        // R7: control word
        read_exp(12'h00C, 32'd1, "R7 ctrl");
        bus_write(12'h00C, 32'h0);
        read_exp(12'h00C, 32'd1, "R7 ctrl after write");
        // R1: counting
        repeat (3 * DIV) @(negedge clk);
        bus_read(12'h000, "R1 count advances");
        // R2: preset and readback
        wait_after_tick();
        bus_write(12'h008, 32'h1234_5678);
        read_exp(12'h008, 32'h1234_5678, "R2 preset readback");
        read_exp(12'h000, 32'h1234_5678, "R2 count preset");
        bus_write_on_tick(12'h008, 32'h0000_0500);
        read_exp(12'h000, 32'h0000_0500, "R2 preset beats tick");
        // R4: immediate match on alarm write
        bus_write(12'h01C, 32'h0);
        wait_after_tick();
        bus_write(12'h008, 32'd100);
        bus_write(12'h004, 32'd100);
        read_exp(12'h014, 32'd1, "R4 alarm write hit");
        // R5: enable keeps bit 0
        bus_write(12'h010, 32'hFFFF_FFFE);
        read_exp(12'h010, 32'd0, "R5 enable bit0 only zero");
        bus_write(12'h010, 32'hFFFF_FFFF);
        read_exp(12'h010, 32'd1, "R5 enable bit0");
        read_exp(12'h018, 32'd1, "R5 gated status");
        // R6: clear with zero data
        bus_write(12'h01C, 32'h0);
        read_exp(12'h014, 32'd0, "R6 clear zero data");
        // R4: preset onto existing alarm
        wait_after_tick();
        bus_write(12'h004, 32'd777);
        bus_write(12'h008, 32'd777);
        read_exp(12'h014, 32'd1, "R4 preset write hit");
        bus_write(12'h01C, 32'hDEAD_BEEF);
        read_exp(12'h014, 32'd0, "R6 clear any data");
        // R3: wrap to alarm 0
        bus_write(12'h008, 32'hFFFF_FFFF);
        bus_write(12'h004, 32'h0);
        read_exp(12'h014, 32'd0, "R3 not yet");
        repeat (2 * DIV) @(negedge clk);
        read_exp(12'h014, 32'd1, "R3 wrap hit");
        bus_read(12'h000, "R3 count after wrap");
        // R9: ignored writes and zero reads
        bus_write(12'h01C, 32'h1);
        wait_after_tick();
        bus_write(12'h000, 32'hAAAA_0000);
        bus_read(12'h000, "R9 count write ignored");
        bus_write(12'h014, 32'h1);
        read_exp(12'h014, 32'd0, "R9 raw write ignored");
        bus_write(12'h018, 32'h1);
        read_exp(12'h018, 32'd0, "R9 gated write ignored");
        read_exp(12'h01C, 32'd0, "R9 clear reads zero");
        read_exp(12'h020, 32'd0, "R9 undefined reads zero");
        read_exp(12'h800, 32'd0, "R9 hole reads zero");
        // R8: identification bytes
        read_exp(12'hFE0, 32'h31, "R8 id0");
        read_exp(12'hFE4, 32'h10, "R8 id1");
        read_exp(12'hFE8, 32'h14, "R8 id2");
        read_exp(12'hFEC, 32'h00, "R8 id3");
        read_exp(12'hFF0, 32'h0D, "R8 id4");
        read_exp(12'hFF4, 32'hF0, "R8 id5");
        read_exp(12'hFF8, 32'h05, "R8 id6");
        read_exp(12'hFFC, 32'hB1, "R8 id7");
        // R11: tick-driven set beats a same-edge clear
        bus_write(12'h004, 32'd501);
        bus_write(12'h008, 32'd500);
        bus_write_on_tick(12'h01C, 32'h1);
        read_exp(12'h014, 32'd1, "R11 set wins");
        // R10: reset mid-run
        do_reset();
        read_exp(12'h000, 32'd0, "R10 count after reset");
        read_exp(12'h014, 32'd0, "R10 raw after reset");
        read_exp(12'h010, 32'd0, "R10 enable after reset");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule